// File: doc/BRIEF.md
# Port Command Slot Engine

This block is the per-port command scheduler of a storage host adapter. It keeps two slot masks: the pending-command mask that software fills by writing ones, and the queued-tag mask that marks commands the device still holds. It also keeps the port's engine-enable bit, the derived running status, and a sticky task-file error flag. When the engine is enabled, the device's task-file status is idle, and no error is waiting, the block offers the lowest pending slot to a downstream command fetcher over a valid/ready handshake. Only one command is in flight at a time.

When the fetcher reports that a command finished cleanly, the block clears that slot's pending bit. A failed command leaves the pending bit set and raises the error flag, which software clears by writing a one to its position. The running status stays high after the enable is dropped until the in-flight command is retired. A helper output gives the lowest slot that is neither pending nor queued, so software can pick where to build its next command.

Top module: `psc_port_engine`

## Requirements
- R1: After reset the pending and queued masks are zero, the enable, running and error outputs are low, no dispatch is offered, and the free-slot helper reports slot 0 as free.
- R2: A pending-mask write ORs its data into the mask. Bits at or above NUM_SLOTS (default 8) are ignored.
- R3: A write that sets the enable takes effect only while running_o is low. A set attempted while running is high leaves the enable at 0. A write of 0 always clears the enable.
- R4: No dispatch is offered while the enable is low. Pending bits written in that state are held and are offered once the enable is set.
- R5: The offered slot is the lowest-numbered pending slot. After a handshake no further slot is offered until that command completes.
- R6: No dispatch is offered while task-file status bit 7 (busy, 0x80) or bit 3 (data request, 0x08) is set.
- R7: A completion with cpl_ok_i=1 clears the pending bit of the in-flight slot on the next clock edge.
- R8: A completion with cpl_ok_i=0 sets the error flag (interrupt-status bit 30) and keeps the pending bit. Dispatch is blocked while the flag is set. Writing clear data with bit 30 set clears the flag; clear data without bit 30 leaves it set.
- R9: running_o is high whenever the enable is set or a command is in flight. After the enable is cleared it falls only when the in-flight command completes.
- R10: free_slot_o is the lowest index below NUM_SLOTS whose pending and queued bits are both clear. free_valid_o is 0 when no such slot exists.
- R11: A queued-mask write ORs its data into the queued mask, and act_done_i clears the bits it has set. Bits at or above NUM_SLOTS are ignored.
- R12: slot_cnt_o advertises NUM_SLOTS minus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_wr_i | input | 1 | Write strobe for the engine-enable bit |
| start_val_i | input | 1 | Value written to the enable |
| issue_wr_i | input | 1 | Write strobe for the pending mask |
| issue_data_i | input | MAX_SLOTS | Ones to set in the pending mask |
| act_wr_i | input | 1 | Write strobe for the queued mask |
| act_data_i | input | MAX_SLOTS | Ones to set in the queued mask |
| act_done_i | input | MAX_SLOTS | Device-side clear of queued bits |
| irq_clr_wr_i | input | 1 | Write strobe for interrupt-status clear |
| irq_clr_data_i | input | 32 | Write-one-to-clear data; bit 30 is the error flag |
| tf_status_i | input | 8 | Task-file status byte from the device |
| disp_valid_o | output | 1 | A slot is offered to the fetcher |
| disp_slot_o | output | SLOT_W | Offered slot index |
| disp_ready_i | input | 1 | Fetcher accepts the offered slot |
| cpl_valid_i | input | 1 | In-flight command has ended |
| cpl_ok_i | input | 1 | 1: clean finish, 0: task-file error |
| start_o | output | 1 | Engine-enable bit |
| running_o | output | 1 | Command-list running status |
| issue_o | output | MAX_SLOTS | Pending mask |
| active_o | output | MAX_SLOTS | Queued mask |
| tfe_o | output | 1 | Task-file error flag |
| free_valid_o | output | 1 | A free slot exists |
| free_slot_o | output | SLOT_W | Lowest free slot |
| slot_cnt_o | output | SLOT_W | Usable slot count minus one |

## Verification
The bench writes pending bits beyond the advertised count and while the engine is off. A design that failed to mask them or failed to hold them would show extra mask bits or an early offer. It stops the engine with a command in flight and then tries to re-enable it at once. A design that dropped running too early or let the enable through would show running low or start high. It fails a command and clears the flag both with and without bit 30, so a design that cleared the pending bit on error, ignored the gate, or cleared the flag on any write would be seen. It also toggles the busy and data-request bits and fills both masks, so a design that dispatched under a busy device or reported an occupied slot as free would be caught.

// File: rtl/psc_pkg.sv
package psc_pkg;
  // task-file status bit positions
  localparam int TF_BUSY_BIT = 7;
  localparam int TF_DREQ_BIT = 3;
  // interrupt-status position of the task-file error flag
  localparam int IRQ_TFE_BIT = 30;
  localparam int IRQ_W       = 32;
endpackage

// File: rtl/psc_lowest_pick.sv
module psc_lowest_pick #(
  parameter int W  = 32,
  parameter int IW = 5
) (
  input  logic [W-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    found = |req;
  end
endmodule

// File: rtl/psc_slot_regs.sv
module psc_slot_regs #(
  parameter int MAX_SLOTS = 32,
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue_set_en,
  input  logic [MAX_SLOTS-1:0] issue_set,
  input  logic                 issue_clr_en,
  input  logic [SLOT_W-1:0]    issue_clr_idx,
  input  logic                 act_set_en,
  input  logic [MAX_SLOTS-1:0] act_set,
  input  logic [MAX_SLOTS-1:0] act_clr,
  output logic [MAX_SLOTS-1:0] issue_q,
  output logic [MAX_SLOTS-1:0] act_q
);
  localparam logic [MAX_SLOTS-1:0] USE_MASK =
    MAX_SLOTS'((64'd1 << NUM_SLOTS) - 64'd1);

  logic [MAX_SLOTS-1:0] issue_d, act_d, clr_onehot;
  logic                 issue_ce, act_ce;

  always_comb begin
    clr_onehot = '0;
    if (issue_clr_en) clr_onehot[issue_clr_idx] = 1'b1;
    issue_ce = issue_set_en | issue_clr_en;
    issue_d  = issue_q & ~clr_onehot;
    if (issue_set_en) issue_d = issue_d | (issue_set & USE_MASK);
    act_ce = act_set_en | (|act_clr);
    act_d  = act_q & ~act_clr;
    if (act_set_en) act_d = act_d | (act_set & USE_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      issue_q <= '0;
    end else if (issue_ce) begin
      issue_q <= issue_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (act_ce) begin
      act_q <= act_d;
    end
  end
endmodule

// File: rtl/psc_ctrl.sv
module psc_ctrl
  import psc_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_wr,
  input  logic              start_val,
  input  logic              has_work,
  input  logic [SLOT_W-1:0] pick_slot,
  input  logic [7:0]        tf_status,
  input  logic              disp_ready,
  input  logic              cpl_valid,
  input  logic              cpl_ok,
  input  logic              irq_clr_wr,
  input  logic [IRQ_W-1:0]  irq_clr_data,
  output logic              start_q,
  output logic              running,
  output logic              disp_valid,
  output logic [SLOT_W-1:0] cur_slot_q,
  output logic              done_ok,
  output logic              tfe_q
);
  logic              inflight_q, inflight_d, start_d, tfe_d;
  logic              start_ce, inflight_ce, tfe_ce, slot_ce;
  logic              tf_block, take, retire;

  always_comb begin
    running  = start_q | inflight_q;
    tf_block = tf_status[TF_BUSY_BIT] | tf_status[TF_DREQ_BIT];
    disp_valid = start_q & ~inflight_q & has_work & ~tf_block & ~tfe_q;
    take     = disp_valid & disp_ready;
    retire   = inflight_q & cpl_valid;
    done_ok  = retire & cpl_ok;

    // enable: a set is accepted only when running is low
    start_ce = start_wr & (~start_val | ~running);
    start_d  = start_val;

    inflight_ce = take | retire;
    inflight_d  = take;
    slot_ce     = take;

    tfe_ce = (retire & ~cpl_ok) | (irq_clr_wr & irq_clr_data[IRQ_TFE_BIT]);
    tfe_d  = retire & ~cpl_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
    end else if (start_ce) begin
      start_q <= start_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight_q <= 1'b0;
    end else if (inflight_ce) begin
      inflight_q <= inflight_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_slot_q <= '0;
    end else if (slot_ce) begin
      cur_slot_q <= pick_slot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tfe_q <= 1'b0;
    end else if (tfe_ce) begin
      tfe_q <= tfe_d;
    end
  end
endmodule

// File: rtl/psc_port_engine.sv
module psc_port_engine
  import psc_pkg::*;
#(
  parameter int MAX_SLOTS = 32,
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = $clog2(MAX_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_wr_i,
  input  logic                 start_val_i,
  input  logic                 issue_wr_i,
  input  logic [MAX_SLOTS-1:0] issue_data_i,
  input  logic                 act_wr_i,
  input  logic [MAX_SLOTS-1:0] act_data_i,
  input  logic [MAX_SLOTS-1:0] act_done_i,
  input  logic                 irq_clr_wr_i,
  input  logic [31:0]          irq_clr_data_i,
  input  logic [7:0]           tf_status_i,
  output logic                 disp_valid_o,
  output logic [SLOT_W-1:0]    disp_slot_o,
  input  logic                 disp_ready_i,
  input  logic                 cpl_valid_i,
  input  logic                 cpl_ok_i,
  output logic                 start_o,
  output logic                 running_o,
  output logic [MAX_SLOTS-1:0] issue_o,
  output logic [MAX_SLOTS-1:0] active_o,
  output logic                 tfe_o,
  output logic                 free_valid_o,
  output logic [SLOT_W-1:0]    free_slot_o,
  output logic [SLOT_W-1:0]    slot_cnt_o
);
  localparam logic [MAX_SLOTS-1:0] USE_MASK =
    MAX_SLOTS'((64'd1 << NUM_SLOTS) - 64'd1);

  logic [MAX_SLOTS-1:0] issue_q, act_q, free_req;
  logic                 has_work, done_ok;
  logic [SLOT_W-1:0]    pick_slot, cur_slot;

  psc_slot_regs #(
    .MAX_SLOTS(MAX_SLOTS), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue_set_en (issue_wr_i),
    .issue_set    (issue_data_i),
    .issue_clr_en (done_ok),
    .issue_clr_idx(cur_slot),
    .act_set_en   (act_wr_i),
    .act_set      (act_data_i),
    .act_clr      (act_done_i),
    .issue_q      (issue_q),
    .act_q        (act_q)
  );

  psc_lowest_pick #(.W(MAX_SLOTS), .IW(SLOT_W)) u_pick_issue (
    .req  (issue_q),
    .found(has_work),
    .idx  (pick_slot)
  );

  assign free_req = ~(issue_q | act_q) & USE_MASK;

  psc_lowest_pick #(.W(MAX_SLOTS), .IW(SLOT_W)) u_pick_free (
    .req  (free_req),
    .found(free_valid_o),
    .idx  (free_slot_o)
  );

  psc_ctrl #(.SLOT_W(SLOT_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_wr    (start_wr_i),
    .start_val   (start_val_i),
    .has_work    (has_work),
    .pick_slot   (pick_slot),
    .tf_status   (tf_status_i),
    .disp_ready  (disp_ready_i),
    .cpl_valid   (cpl_valid_i),
    .cpl_ok      (cpl_ok_i),
    .irq_clr_wr  (irq_clr_wr_i),
    .irq_clr_data(irq_clr_data_i),
    .start_q     (start_o),
    .running     (running_o),
    .disp_valid  (disp_valid_o),
    .cur_slot_q  (cur_slot),
    .done_ok     (done_ok),
    .tfe_q       (tfe_o)
  );

  assign disp_slot_o = pick_slot;
  assign issue_o     = issue_q;
  assign active_o    = act_q;
  assign slot_cnt_o  = SLOT_W'(NUM_SLOTS - 1);
endmodule

// File: rtl/psc_port_engine_chk.sv
module psc_port_engine_chk #(
  parameter int MAX_SLOTS = 32,
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [7:0]           tf_status_i,
  input logic                 disp_valid_o,
  input logic                 disp_ready_i,
  input logic                 cpl_valid_i,
  input logic                 cpl_ok_i,
  input logic                 start_o,
  input logic                 running_o,
  input logic [MAX_SLOTS-1:0] issue_o,
  input logic [MAX_SLOTS-1:0] active_o,
  input logic                 tfe_o,
  input logic                 free_valid_o,
  input logic [SLOT_W-1:0]    free_slot_o
);
  logic busy_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else if (disp_valid_o && disp_ready_i) busy_q <= 1'b1;
    else if (cpl_valid_i) busy_q <= 1'b0;
  end

  // R5
  one_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid_o && disp_ready_i) |=> !disp_valid_o);

  // R3
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_o) |-> $past(!running_o));

  // R9
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running_o) |-> !start_o);

  // R6
  tf_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid_o |-> !(tf_status_i[7] || tf_status_i[3]));

  // R2
  cap_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((issue_o | active_o) >> NUM_SLOTS) == '0);

  // R8
  err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cpl_valid_i && !cpl_ok_i) |=> tfe_o);

  // R8
  err_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tfe_o |-> !disp_valid_o);

  // R10
  free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_valid_o |-> !(issue_o[free_slot_o] || active_o[free_slot_o]));
endmodule

bind psc_port_engine psc_port_engine_chk #(
  .MAX_SLOTS(MAX_SLOTS), .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tf_status_i (tf_status_i),
  .disp_valid_o(disp_valid_o),
  .disp_ready_i(disp_ready_i),
  .cpl_valid_i (cpl_valid_i),
  .cpl_ok_i    (cpl_ok_i),
  .start_o     (start_o),
  .running_o   (running_o),
  .issue_o     (issue_o),
  .active_o    (active_o),
  .tfe_o       (tfe_o),
  .free_valid_o(free_valid_o),
  .free_slot_o (free_slot_o)
);

// File: tb/tb_psc_port_engine.sv
module tb_psc_port_engine;
  localparam int MAXS = 32;
  localparam int NS   = 8;
  localparam int SW   = 5;

  logic            clk, rst_n;
  logic            start_wr_i, start_val_i, issue_wr_i, act_wr_i, irq_clr_wr_i;
  logic [MAXS-1:0] issue_data_i, act_data_i, act_done_i;
  logic [31:0]     irq_clr_data_i;
  logic [7:0]      tf_status_i;
  logic            disp_valid_o, disp_ready_i, cpl_valid_i, cpl_ok_i;
  logic [SW-1:0]   disp_slot_o, free_slot_o, slot_cnt_o;
  logic            start_o, running_o, tfe_o, free_valid_o;
  logic [MAXS-1:0] issue_o, active_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  psc_port_engine #(.MAX_SLOTS(MAXS), .NUM_SLOTS(NS)) dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_issue(input logic [MAXS-1:0] m);
    issue_wr_i = 1'b1; issue_data_i = m; tick();
    issue_wr_i = 1'b0; issue_data_i = '0;
  endtask

  task automatic wr_start(input logic v);
    start_wr_i = 1'b1; start_val_i = v; tick();
    start_wr_i = 1'b0; start_val_i = 1'b0;
  endtask

  task automatic wr_act(input logic [MAXS-1:0] m);
    act_wr_i = 1'b1; act_data_i = m; tick();
    act_wr_i = 1'b0; act_data_i = '0;
  endtask

  task automatic irq_clear(input logic [31:0] d);
    irq_clr_wr_i = 1'b1; irq_clr_data_i = d; tick();
    irq_clr_wr_i = 1'b0; irq_clr_data_i = '0;
  endtask

  task automatic take_slot(input string req, input int exp_slot);
    chk({req, " offer"}, 32'(disp_valid_o), 32'd1);
    chk({req, " slot"}, 32'(disp_slot_o), 32'(exp_slot));
    disp_ready_i = 1'b1; tick(); disp_ready_i = 1'b0;
    chk("R5 no offer while in flight", 32'(disp_valid_o), 32'd0);
  endtask

  task automatic complete(input logic ok);
    cpl_valid_i = 1'b1; cpl_ok_i = ok; tick();
    cpl_valid_i = 1'b0; cpl_ok_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 issue", issue_o, 32'h0);
    chk("R1 active", active_o, 32'h0);
    chk("R1 start", 32'(start_o), 32'd0);
    chk("R1 running", 32'(running_o), 32'd0);
    chk("R1 tfe", 32'(tfe_o), 32'd0);
    chk("R1 offer", 32'(disp_valid_o), 32'd0);
    chk("R1 free valid", 32'(free_valid_o), 32'd1);
    chk("R1 free slot", 32'(free_slot_o), 32'd0);
    chk("R12 slot count", 32'(slot_cnt_o), 32'(NS - 1));
  endtask

  task automatic t_issue_held();
    wr_issue(32'h0000_0305);
    chk("R2 mask above count", issue_o, 32'h05);
    chk("R4 held while disabled", 32'(disp_valid_o), 32'd0);
    chk("R10 free after issue", 32'(free_slot_o), 32'd1);
  endtask

  task automatic t_dispatch();
    wr_start(1'b1);
    chk("R3 start accepted", 32'(start_o), 32'd1);
    chk("R9 running with start", 32'(running_o), 32'd1);
    take_slot("R5 lowest first", 0);
    complete(1'b1);
    chk("R7 clear on success", issue_o, 32'h04);
    chk("R5 next offer", 32'(disp_slot_o), 32'd2);
  endtask

  task automatic t_tf_block();
    tf_status_i = 8'h80; tick();
    chk("R6 busy blocks", 32'(disp_valid_o), 32'd0);
    tf_status_i = 8'h08; tick();
    chk("R6 data request blocks", 32'(disp_valid_o), 32'd0);
    tf_status_i = 8'h50; tick();
    chk("R6 idle allows", 32'(disp_valid_o), 32'd1);
  endtask

  task automatic t_error();
    take_slot("R8 before error", 2);
    complete(1'b0);
    chk("R8 flag set", 32'(tfe_o), 32'd1);
    chk("R8 issue kept", issue_o, 32'h04);
    chk("R8 dispatch gated", 32'(disp_valid_o), 32'd0);
    irq_clear(32'h0000_0001);
    chk("R8 other bit no clear", 32'(tfe_o), 32'd1);
    irq_clear(32'h4000_0000);
    chk("R8 bit30 clears", 32'(tfe_o), 32'd0);
    take_slot("R8 retry", 2);
    complete(1'b1);
    chk("R7 retry cleared", issue_o, 32'h0);
  endtask

  task automatic t_stop();
    wr_issue(32'h02);
    take_slot("R9 setup", 1);
    wr_start(1'b0);
    chk("R9 start cleared", 32'(start_o), 32'd0);
    chk("R9 running held", 32'(running_o), 32'd1);
    wr_start(1'b1);
    chk("R3 set ignored while running", 32'(start_o), 32'd0);
    complete(1'b1);
    chk("R9 running falls", 32'(running_o), 32'd0);
    wr_start(1'b1);
    chk("R3 set after idle", 32'(start_o), 32'd1);
  endtask

  task automatic t_free();
    wr_act(32'h0F);
    chk("R11 active set", active_o, 32'h0F);
    chk("R10 free past active", 32'(free_slot_o), 32'd4);
    wr_issue(32'h10);
    chk("R10 free past both", 32'(free_slot_o), 32'd5);
    wr_act(32'hE0);
    chk("R10 none free", 32'(free_valid_o), 32'd0);
    act_done_i = 32'h08; tick(); act_done_i = '0;
    chk("R11 device clear", active_o, 32'hE7);
    chk("R10 freed slot", 32'(free_slot_o), 32'd3);
    wr_act(32'h100);
    chk("R11 mask above count", active_o, 32'hE7);
  endtask

  initial begin
    rst_n = 1'b0;
    start_wr_i = 0; start_val_i = 0; issue_wr_i = 0; act_wr_i = 0;
    irq_clr_wr_i = 0; issue_data_i = '0; act_data_i = '0; act_done_i = '0;
    irq_clr_data_i = '0; tf_status_i = 8'h50;
    disp_ready_i = 0; cpl_valid_i = 0; cpl_ok_i = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_issue_held();
    t_dispatch();
    t_tf_block();
    t_error();
    t_stop();
    t_free();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule